// File: doc/BRIEF.md
# Bit Index Shifter Peripheral

This peripheral helps a byte-wide CPU reach single flag bits packed into memory. Firmware loads a 16-bit base address and then writes a bit index. The unit then offers, on the same byte-wide read/write bus, the address of the byte that holds the bit and a one-hot mask that selects the bit inside that byte. It also offers the inverted mask. With these values firmware can set, clear, test or toggle the flag. It needs no multi-bit shift of its own. The CPU does the read-modify-write of the target byte, not the unit.

The unit has four byte offsets. Offsets 0 and 1 hold the base address, with the high byte at offset 0. Offset 2 is the bit index when written and the mask when read. Offset 3 is a read-only copy of the inverted mask. A base write puts the unit back into its loading state. After an index write the unit is in its shifted state. In that state the address offsets show the computed byte address in place of the base.

Top module: `bit_index_shifter`

## Requirements
- R1: After reset, offsets 0 and 1 read 0x00, offset 2 reads 0x00 and offset 3 reads 0xFF.
- R2: A write to offset 0 sets bits 15:8 of the base and a write to offset 1 sets bits 7:0. In the loading state, offsets 0 and 1 read back those two bytes.
- R3: A write to either base offset returns the unit to the loading state. Offsets 0 and 1 then read the base again, offset 2 reads 0x00 and offset 3 reads 0xFF.
- R4: A write of index I to offset 2 enters the shifted state. Offset 0 then reads the high byte and offset 1 the low byte of (base + I/8) modulo 65536, where I/8 is I shifted right by three.
- R5: In the shifted state, offset 2 reads 1 shifted left by I modulo 8.
- R6: In the shifted state, offset 3 reads the bitwise inverse of the offset-2 mask.
- R7: The result can be read on the first cycle after the index write, and it stays the same until the next write.
- R8: A write to offset 3 changes no state. All four offsets read the same afterwards.
- R9: The read bus is 0x00 whenever the unit is not selected, or when it is selected with write asserted.
- R10: The address sum wraps modulo 65536. For example, base 0xFFFE with index 0x1F gives 0x0001.
- R11: A further index write in the shifted state computes from the stored base, not from the shifted address shown on readback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Unit select |
| bus_we | input | 1 | Write strobe (1 = write, 0 = read) |
| bus_ofs | input | 2 | Register offset within the unit |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |

## Verification
The assertions check these rules on every cycle:
- a base write lands in the correct byte lane;
- a base write clears the shifted state;
- the mask stays one-hot while the unit is in the shifted state;
- the registered address equals the earlier base plus the earlier index divided by eight;
- a write to offset 3 leaves the stored state unchanged;
- the read bus stays quiet when the unit is not selected or is being written.

Only the bench scenarios can show the parts seen through the bus alone:
- the big-endian byte order on readback;
- wrap-around of the address sum at the top of the address space;
- a second index write that uses the stored base, not the shifted address;
- the result holding steady across idle cycles.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  parameter int unsigned BSH_DW    = 8;
  parameter int unsigned BSH_LANES = 2;
  localparam int unsigned BSH_AW    = BSH_DW * BSH_LANES;
  localparam int unsigned BSH_SEL_W = $clog2(BSH_DW);
  localparam int unsigned BSH_OFS_W = $clog2(BSH_LANES + 2);
  localparam int unsigned BSH_IDX_OFS = BSH_LANES;
  localparam int unsigned BSH_INV_OFS = BSH_LANES + 1;

  typedef logic [BSH_AW-1:0] bsh_addr_t;
  typedef logic [BSH_DW-1:0] bsh_byte_t;

  function automatic bsh_addr_t bsh_byte_addr(input bsh_addr_t base, input bsh_byte_t idx);
    bsh_addr_t step;
    step = bsh_addr_t'(idx >> BSH_SEL_W);
    return base + step;
  endfunction

  function automatic bsh_byte_t bsh_onehot(input bsh_byte_t idx);
    return bsh_byte_t'(1) << idx[BSH_SEL_W-1:0];
  endfunction
endpackage

// File: rtl/bsh_base_reg.sv
module bsh_base_reg
  import bsh_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BSH_LANES-1:0] lane_wr,
  input  bsh_byte_t            wdata,
  output bsh_addr_t            base
);
  generate
    for (genvar g = 0; g < BSH_LANES; g++) begin : g_lane
      localparam int unsigned LSB = (BSH_LANES - 1 - g) * BSH_DW;
      bsh_byte_t lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else if (lane_wr[g]) lane_q <= wdata;
      end
      assign base[LSB +: BSH_DW] = lane_q;

      a_r2_lane_store: assert property (@(posedge clk) disable iff (!rst_n)
        lane_wr[g] |=> base[LSB +: BSH_DW] == $past(wdata));
    end
  endgenerate
endmodule

// File: rtl/bsh_shift_core.sv
module bsh_shift_core
  import bsh_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      base_wr,
  input  logic      idx_wr,
  input  bsh_byte_t idx_in,
  input  bsh_addr_t base,
  output logic      shifted,
  output bsh_addr_t res_addr,
  output bsh_byte_t res_mask
);
  logic      shifted_q;
  bsh_addr_t addr_q;
  bsh_byte_t mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shifted_q <= 1'b0;
      addr_q    <= '0;
      mask_q    <= '0;
    end else if (base_wr) begin
      shifted_q <= 1'b0;
      mask_q    <= '0;
    end else if (idx_wr) begin
      shifted_q <= 1'b1;
      addr_q    <= bsh_byte_addr(base, idx_in);
      mask_q    <= bsh_onehot(idx_in);
    end
  end

  assign shifted  = shifted_q;
  assign res_addr = addr_q;
  assign res_mask = mask_q;

  a_r3_base_clears: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> !shifted_q);
  a_r5_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    shifted_q |-> $countones(mask_q) == 1);
  a_r4_addr_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && !base_wr) |=>
      addr_q == bsh_addr_t'($past(base) + {{(BSH_AW-BSH_DW+BSH_SEL_W){1'b0}},
                                           $past(idx_in[BSH_DW-1:BSH_SEL_W])}));
endmodule

// File: rtl/bsh_read_mux.sv
module bsh_read_mux
  import bsh_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [BSH_OFS_W-1:0] ofs,
  input  logic                 shifted,
  input  bsh_addr_t            base,
  input  bsh_addr_t            res_addr,
  input  bsh_byte_t            res_mask,
  output bsh_byte_t            rdata
);
  bsh_addr_t shown_addr;
  bsh_byte_t shown_mask;

  assign shown_addr = shifted ? res_addr : base;
  assign shown_mask = shifted ? res_mask : '0;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int l = 0; l < BSH_LANES; l++) begin
        if (ofs == BSH_OFS_W'(l))
          rdata = shown_addr[(BSH_LANES-1-l)*BSH_DW +: BSH_DW];
      end
      if (ofs == BSH_OFS_W'(BSH_IDX_OFS)) rdata = shown_mask;
      if (ofs == BSH_OFS_W'(BSH_INV_OFS)) rdata = ~shown_mask;
    end
  end

  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
  a_r6_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ofs == BSH_OFS_W'(BSH_INV_OFS) && shifted) |-> (rdata & res_mask) == '0
      && $countones(rdata) == BSH_DW - 1);
endmodule

// File: rtl/bit_index_shifter.sv
module bit_index_shifter
  import bsh_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_cs,
  input  logic                 bus_we,
  input  logic [BSH_OFS_W-1:0] bus_ofs,
  input  logic [BSH_DW-1:0]    bus_wdata,
  output logic [BSH_DW-1:0]    bus_rdata
);
  logic [BSH_LANES-1:0] lane_wr;
  logic base_wr, idx_wr, inv_wr, rd_en, shifted;
  bsh_addr_t base, res_addr;
  bsh_byte_t res_mask;

  generate
    for (genvar g = 0; g < BSH_LANES; g++) begin : g_dec
      assign lane_wr[g] = bus_cs && bus_we && (bus_ofs == BSH_OFS_W'(g));
    end
  endgenerate

  assign base_wr = |lane_wr;
  assign idx_wr  = bus_cs && bus_we && (bus_ofs == BSH_OFS_W'(BSH_IDX_OFS));
  assign inv_wr  = bus_cs && bus_we && (bus_ofs == BSH_OFS_W'(BSH_INV_OFS));
  assign rd_en   = bus_cs && !bus_we;

  bsh_base_reg u_base (
    .clk(clk), .rst_n(rst_n), .lane_wr(lane_wr), .wdata(bus_wdata), .base(base)
  );

  bsh_shift_core u_core (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .idx_wr(idx_wr),
    .idx_in(bus_wdata), .base(base), .shifted(shifted),
    .res_addr(res_addr), .res_mask(res_mask)
  );

  bsh_read_mux u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .ofs(bus_ofs), .shifted(shifted),
    .base(base), .res_addr(res_addr), .res_mask(res_mask), .rdata(bus_rdata)
  );

  a_r8_inv_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    inv_wr |=> $stable(base) && $stable(res_addr) && $stable(res_mask) && $stable(shifted));
endmodule

// File: tb/tb_bit_index_shifter.sv
module tb_bit_index_shifter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cs = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_ofs = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_index_shifter dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] ofs, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_ofs = ofs; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ofs, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_ofs = ofs;
    #1 d = bus_rdata;
    bus_cs = 1'b0;
  endtask

  task automatic expect_all(input string req, input logic [15:0] a, input logic [7:0] m);
    logic [7:0] v;
    rd(2'd0, v); check(req, v, a[15:8]);
    rd(2'd1, v); check(req, v, a[7:0]);
    rd(2'd2, v); check(req, v, m);
    rd(2'd3, v); check(req, v, ~m);
  endtask

  function automatic logic [15:0] exp_addr(input int b, input int i);
    return 16'((b + i / 8) % 65536);
  endfunction

  function automatic logic [7:0] exp_mask(input int i);
    return 8'(2 ** (i % 8));
  endfunction

  task automatic t_reset;
    expect_all("R1", 16'h0000, 8'h00);
  endtask

  task automatic t_base;
    wr(2'd0, 8'h12); wr(2'd1, 8'h34);
    expect_all("R2", 16'h1234, 8'h00);
  endtask

  task automatic t_shift(input int b, input int i, input string req);
    wr(2'd0, 8'(b / 256)); wr(2'd1, 8'(b % 256));
    wr(2'd2, 8'(i));
    expect_all(req, exp_addr(b, i), exp_mask(i));
  endtask

  task automatic t_timing;
    logic [7:0] v;
    wr(2'd0, 8'h20); wr(2'd1, 8'h00);
    wr(2'd2, 8'h0B);
    rd(2'd2, v); check("R7 first cycle mask", v, 8'h08);
    repeat (5) @(negedge clk);
    expect_all("R7 hold", 16'h2001, 8'h08);
  endtask

  task automatic t_clear;
    wr(2'd0, 8'h40); wr(2'd1, 8'h10); wr(2'd2, 8'h45);
    wr(2'd1, 8'h11);
    expect_all("R3", 16'h4011, 8'h00);
  endtask

  task automatic t_inv_write;
    wr(2'd0, 8'h30); wr(2'd1, 8'h00); wr(2'd2, 8'h1A);
    wr(2'd3, 8'h5A);
    expect_all("R8", 16'h3003, 8'h04);
  endtask

  task automatic t_quiet;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0; bus_ofs = 2'd3;
    #1 check("R9 deselected", bus_rdata, 8'h00);
    bus_cs = 1'b1; bus_we = 1'b1; bus_ofs = 2'd3; bus_wdata = 8'h00;
    #1 check("R9 writing", bus_rdata, 8'h00);
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic t_restack;
    wr(2'd0, 8'h10); wr(2'd1, 8'h00);
    wr(2'd2, 8'h10);
    wr(2'd2, 8'h21);
    expect_all("R11", 16'h1004, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_base();
    t_shift(16'h1234, 8'h00, "R4 R5 R6 idx0");
    t_shift(16'h0100, 8'hFF, "R4 R5 R6 idxFF");
    t_shift(16'hA0F0, 8'h5D, "R4 R5 R6 mid");
    t_shift(16'hFFFE, 8'h1F, "R10 wrap");
    t_timing();
    t_clear();
    t_inv_write();
    t_quiet();
    t_restack();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule